// File: doc/BRIEF.md
# Shared-Pin ADC Serial Reader

This block runs on the host side of a converter that has one combined output line. The line first goes low to show that a new result is ready. It then carries that result one bit at a time. The block passes the line through a synchronizer and watches for the ready level. It then drives a clean serial clock, divided down from the system clock, and shifts in one 24-bit result with the most significant bit first.

When `park_en` is set, the block issues one extra clock after the last data bit. That clock forces the line high, so the next ready indication is a plain high-to-low change that can be polled. When `park_en` is clear, the block waits until the line has gone high again before it can recognise another ready level.

The finished result appears on a parallel port as a signed two's-complement word, together with a strobe that lasts one cycle.

Top module: `adc_pin_reader`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `sclk` is low, `word_valid` is low and no transfer is in progress.
- R2: A transfer starts only when the synchronized `shared_in` level is low while the block is idle, and only if that level has been seen high since reset or since the last transfer. A line held low through reset and afterwards produces no `sclk` edge.
- R3: `sclk` idles low. Each high phase and each low phase of `sclk` lasts exactly `HALF_DIV` system clocks, and `sclk` changes only at those boundaries.
- R4: One transfer issues exactly 24 rising edges on `sclk` when `park_en` is low, and exactly 25 when `park_en` is high. `park_en` is sampled when the transfer starts.
- R5: Each data bit is sampled at the falling edge of `sclk` that follows the rising edge presenting it. The first bit sampled becomes `word[23]` and the last becomes `word[0]`.
- R6: When a transfer completes, `word_valid` is high for exactly one cycle and `word` holds the received value. `word` keeps that value until the next completion.
- R7: With `park_en` low, if `shared_in` stays low after a transfer, no further `sclk` edge occurs until the line has been high.
- R8: With `park_en` high, the extra clock leaves the line high. The next low level then starts a new transfer without any other action.
- R9: `word` is two's complement: a bit 23 value of 1 means negative. 0x800000 reads as -8388608 and 0x7FFFFF reads as +8388607.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| park_en | input | 1 | 1: issue the extra clock that parks the line high after the data |
| shared_in | input | 1 | Combined ready/data line from the converter |
| sclk | output | 1 | Generated serial clock, idles low |
| word | output | 24 | Received result, signed two's complement |
| word_valid | output | 1 | One-cycle strobe marking a new `word` |

## Verification
The hardest situation to reach is re-arming. A line that is already low must not start a transfer. This has to be shown both when the line is held low through reset and when the last data bit is 0 with parking off. The stimulus holds the line low across reset, and it also uses a word whose last bit is 0 with parking off. In both cases it counts `sclk` edges for a long idle window before raising the line. Back-to-back parked reads, with random words and random parking choices, show that the high level forced by the extra clock re-arms detection without any help from the host.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   typedef enum logic [0:0] {
      RD_IDLE  = 1'b0,
      RD_SHIFT = 1'b1
   } rd_state_t;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("adc_rd_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b0;
               else     chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[gi] <= 1'b0;
               else     chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic tick
);
   localparam int DW = (HALF > 2) ? $clog2(HALF) : 1;
   localparam logic [DW-1:0] TOP = DW'(HALF - 1);

   generate
      if (HALF < 3) begin : g_bad
         $error("adc_rd_tick: HALF must be at least 3");
      end
   endgenerate

   logic [DW-1:0] cnt;

   assign tick = en && (cnt == TOP);

   always_ff @(posedge clk) begin
      if (rst || !en || tick) cnt <= '0;
      else                    cnt <= cnt + DW'(1);
   end

   a_r3_tick_needs_enable: assert property (@(posedge clk) disable iff (rst)
      !en |=> !tick);
endmodule

// File: rtl/adc_pin_reader.sv
module adc_pin_reader #(
   parameter int DATA_W      = 24,
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     park_en,
   input  logic                     shared_in,
   output logic                     sclk,
   output logic signed [DATA_W-1:0] word,
   output logic                     word_valid
);
   import adc_rd_pkg::*;

   localparam int CW = $clog2(DATA_W + 2);
   localparam logic [CW-1:0] LAST_PLAIN  = CW'(DATA_W);
   localparam logic [CW-1:0] LAST_PARKED = CW'(DATA_W + 1);

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("adc_pin_reader: DATA_W must be at least 2");
      end
      if (HALF_DIV < SYNC_STAGES + 1) begin : g_bad_div
         $error("adc_pin_reader: HALF_DIV too small for synchronizer latency");
      end
   endgenerate

   rd_state_t          state;
   logic               pin_s;
   logic               tick;
   logic               armed;
   logic               park_q;
   logic               sclk_q;
   logic [CW-1:0]      pulses;
   logic [CW-1:0]      pulses_nx;
   logic [CW-1:0]      last;
   logic [DATA_W-1:0]  sh;
   logic [DATA_W-1:0]  word_q;
   logic               valid_q;

   adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (shared_in),
      .dout(pin_s)
   );

   adc_rd_tick #(.HALF(HALF_DIV)) u_tick (
      .clk (clk),
      .rst (rst),
      .en  (state == RD_SHIFT),
      .tick(tick)
   );

   assign pulses_nx = pulses + CW'(1);
   assign last      = park_q ? LAST_PARKED : LAST_PLAIN;

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= RD_IDLE;
         armed   <= 1'b0;
         park_q  <= 1'b0;
         sclk_q  <= 1'b0;
         pulses  <= '0;
         sh      <= '0;
         word_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         case (state)
            RD_IDLE: begin
               if (pin_s) begin
                  armed <= 1'b1;
               end else if (armed) begin
                  state  <= RD_SHIFT;
                  armed  <= 1'b0;
                  park_q <= park_en;
                  pulses <= '0;
               end
            end
            RD_SHIFT: begin
               if (tick) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                  end else begin
                     sclk_q <= 1'b0;
                     pulses <= pulses_nx;
                     if (pulses < LAST_PLAIN)
                        sh <= {sh[DATA_W-2:0], pin_s};
                     if (pulses_nx == last) begin
                        state   <= RD_IDLE;
                        valid_q <= 1'b1;
                        word_q  <= (pulses < LAST_PLAIN) ? {sh[DATA_W-2:0], pin_s} : sh;
                     end
                  end
               end
            end
            default: state <= RD_IDLE;
         endcase
      end
   end

   assign sclk       = sclk_q;
   assign word       = word_q;
   assign word_valid = valid_q;

   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> (!sclk_q && !valid_q && state == RD_IDLE));

   a_r2_high_line_no_start: assert property (@(posedge clk) disable iff (rst)
      (state == RD_IDLE && pin_s) |=> state == RD_IDLE);

   a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
      state == RD_IDLE |-> !sclk_q);

   a_r3_edges_on_tick: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(sclk_q));

   a_r4_pulse_bound: assert property (@(posedge clk) disable iff (rst)
      pulses <= LAST_PARKED);

   a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
      valid_q |=> !valid_q);

   a_r6_word_held: assert property (@(posedge clk) disable iff (rst)
      !valid_q |-> $stable(word_q));
endmodule

// File: tb/tb_adc_pin_reader.sv
module tb_adc_pin_reader;
   localparam int W    = 24;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic park_en = 1'b0;
   logic pin = 1'b0;
   logic sclk, valid;
   logic signed [W-1:0] data;

   always #2 clk = ~clk;

   adc_pin_reader #(.DATA_W(W), .HALF_DIV(HALF), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst(rst), .park_en(park_en), .shared_in(pin),
      .sclk(sclk), .word(data), .word_valid(valid)
   );

   int checks = 0, fails = 0, rises = 0, nvalid = 0, bitn = 0, cyc = 0;
   logic [W-1:0] word_m = '0;
   logic [W-1:0] got = '0;
   time t_rise = 0;

   function automatic void chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endfunction

   // converter model: each rising edge presents the next bit, the extra one parks high
   always @(posedge sclk) begin
      rises++;
      t_rise = $time;
      if (bitn < W) pin <= word_m[W-1-bitn];
      else          pin <= 1'b1;
      bitn++;
   end

   always @(negedge sclk) chk(($time - t_rise) == HALF * 4, "R3 high time",
                              longint'($time - t_rise), HALF * 4);

   always @(negedge clk) if (valid) begin got = data; nvalid++; end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic do_read(input logic [W-1:0] w, input bit park);
      int n0;
      @(negedge clk);
      park_en = park;
      word_m  = w;
      bitn    = 0;
      rises   = 0;
      n0      = nvalid;
      pin     = 1'b0;
      for (int i = 0; i < 4000 && nvalid == n0; i++) @(negedge clk);
      chk(got == w, "R5 word", got, w);
      chk(rises == (park ? 25 : 24), park ? "R4 parked count" : "R4 plain count", rises, park ? 25 : 24);
      repeat (3) @(negedge clk);
      chk(nvalid == n0 + 1, "R6 one strobe", nvalid - n0, 1);
      chk(data == w, "R6 word held", data, w);
      if (!park) begin
         repeat (40) @(negedge clk);
         chk(rises == 24, "R7 no restart before high", rises, 24);
         pin = 1'b1;
      end
      repeat (8) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h00C0FFEE));
      rst = 1'b1;
      pin = 1'b0;
      repeat (5) @(negedge clk);
      chk(sclk == 1'b0, "R1 sclk", sclk, 0);
      chk(valid == 1'b0, "R1 valid", valid, 0);
      rst = 1'b0;
      repeat (40) @(negedge clk);
      chk(rises == 0, "R2 low through reset", rises, 0);
      chk(sclk == 1'b0, "R3 idle low", sclk, 0);
      pin = 1'b1;
      repeat (10) @(negedge clk);
      chk(rises == 0, "R2 high line", rises, 0);

      do_read(24'hA5C396, 1'b0);
      do_read(24'hFFFFFE, 1'b0);          // R7: line stays low after the read
      do_read(24'h800000, 1'b1);
      chk($signed(got) == -8388608, "R9 most negative", $signed(got), -8388608);
      do_read(24'h7FFFFF, 1'b1);          // R8: starts straight after the parked read
      chk($signed(got) == 8388607, "R9 most positive", $signed(got), 8388607);
      do_read(24'h000000, 1'b1);
      do_read(24'h000001, 1'b0);

      for (int k = 0; k < 16; k++) begin
         logic [W-1:0] rw;
         bit rp;
         rw = W'($urandom);
         rp = 1'($urandom);
         do_read(rw, rp);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule